// File: doc/BRIEF.md
# Iterative Halving Sum Reducer

This block folds a bank of partial sums, held in an internal register array, into a single total. Software or an upstream engine fills the bank through a simple write port while the block is idle. It then issues a start pulse together with the number of valid entries and a mode select. The reduction proceeds in steps. In each step, the low part of the bank adds in the matching high entries, all lanes in parallel. The next step does not begin until every add of the current step has been written back.

Two step schedules are offered, and both give an exact total for any entry count, not only powers of two.

- **Fold mode** (`mode_i`=0) starts from the full count. Before each halving it checks the count: when the count is odd, the last live entry is first folded into entry 0, then the count is halved rounding down.
- **Ceiling mode** (`mode_i`=1) halves rounding up. Only the entries between the new half and the previous upper limit send their values down.

When the total is ready, `done_o` pulses for one cycle and `sum_o` holds the total.

Top module: `halving_sum_unit`

## Requirements
- R1: After reset `busy_o` and `done_o` are low and `sum_o` is zero.
- R2: With `mode_i`=0 the reported total equals the sum of entries 0 to count-1, for every count from 1 to N_MAX.
- R3: With `mode_i`=1 the reported total equals the sum of entries 0 to count-1, for every count from 1 to N_MAX.
- R4: For count 1, `done_o` is high in the cycle after the edge that samples `start_i`. Otherwise `done_o` rises 2*S edges after that sampling edge. S is floor(log2 count) in mode 0 and ceil(log2 count) in mode 1, since every step is one prepare cycle plus one add cycle.
- R5: `done_o` lasts exactly one cycle, and `sum_o` keeps the total unchanged until the next accepted start.
- R6: A start pulse while `busy_o` is high has no effect on the running reduction, its total or its timing.
- R7: Writes while `busy_o` is high are dropped and do not disturb the running total.
- R8: A start with count 0 or count above N_MAX is ignored and `busy_o` stays low.
- R9: A write with `wr_en_i` high while idle stores `wr_data_i` into the entry `wr_idx_i`, and that value takes part in the next reduction.
- R10: All additions wrap modulo 2^W.
- R11: `busy_o` is high from the sampling edge of an accepted start through the `done_o` cycle, and low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Entry write strobe, honoured only while idle |
| wr_idx_i | input | IW | Entry index to write |
| wr_data_i | input | W | Value to write |
| start_i | input | 1 | Launch a reduction |
| count_i | input | CW | Number of live entries, 1 to N_MAX |
| mode_i | input | 1 | 0 fold schedule, 1 ceiling schedule |
| busy_o | output | 1 | Reduction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sum_o | output | W | Reduced total |

## Verification
The bench builds the block with N_MAX=12 and W=8. A capacity that is not a power of two puts every odd count and the full bank on the same footing as the even ones. It also leaves count 13 representable on the count port, so the out-of-range start can be driven. The narrow width makes wraparound of the total happen on most random loads, so the modulo behaviour is exercised constantly rather than in a single directed case.

// File: rtl/halving_sum_pkg.sv
`timescale 1ns/1ps
package halving_sum_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PREP, ST_PAIR, ST_DONE} hs_state_e;
  typedef enum logic {MODE_FOLD = 1'b0, MODE_CEIL = 1'b1} hs_mode_e;
endpackage

// File: rtl/halving_sum_ctrl.sv
`timescale 1ns/1ps
module halving_sum_ctrl
  import halving_sum_pkg::*;
#(
  parameter int N_MAX = 16,
  parameter int CW    = $clog2(N_MAX + 1),
  parameter int IW    = $clog2(N_MAX)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] count_i,
  input  logic          mode_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          fold_en_o,
  output logic [IW-1:0] fold_idx_o,
  output logic          pair_en_o,
  output logic [CW-1:0] shift_o,
  output logic [CW-1:0] pairs_o
);
  localparam logic [CW:0] NMAX_W = (CW+1)'(N_MAX);

  hs_state_e     state_q;
  hs_mode_e      mode_q;
  logic [CW-1:0] half_q, lim_q, pairs_q;
  logic [CW:0]   half_inc;
  logic [CW-1:0] half_ceil, half_floor;
  logic          count_ok, launch;

  assign half_inc   = {1'b0, half_q} + {{CW{1'b0}}, 1'b1};
  assign half_ceil  = half_inc[CW:1];
  assign half_floor = half_q >> 1;
  assign count_ok   = (count_i != '0) && ({1'b0, count_i} <= NMAX_W);
  assign launch     = (state_q == ST_IDLE) && start_i && count_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_FOLD;
      half_q  <= '0;
      lim_q   <= '0;
      pairs_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (launch) begin
          half_q  <= count_i;
          lim_q   <= count_i;
          mode_q  <= hs_mode_e'(mode_i);
          state_q <= (count_i == CW'(1)) ? ST_DONE : ST_PREP;
        end
        ST_PREP: begin
          if (mode_q == MODE_FOLD) begin
            half_q  <= half_floor;
            pairs_q <= half_floor;
          end else begin
            half_q  <= half_ceil;
            pairs_q <= lim_q - half_ceil;  // senders in [half, limit)
            lim_q   <= half_ceil;
          end
          state_q <= ST_PAIR;
        end
        ST_PAIR: state_q <= (half_q == CW'(1)) ? ST_DONE : ST_PREP;
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // odd-count fix runs in the prepare cycle, apart from the pair adds
  assign fold_en_o  = (state_q == ST_PREP) && (mode_q == MODE_FOLD) && half_q[0];
  assign fold_idx_o = IW'(half_q - CW'(1));
  assign pair_en_o  = (state_q == ST_PAIR);
  assign shift_o    = half_q;
  assign pairs_o    = pairs_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);

  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R4
  half_shrink_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PREP) |=> (half_q < $past(half_q)));
  // R6
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (mode_q == $past(mode_q)));
  // R8
  bad_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && !count_ok) |=> !busy_o);
  // R3
  pair_span_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_en_o |-> (pairs_o <= shift_o) && (pairs_o != '0));
endmodule

// File: rtl/halving_sum_bank.sv
`timescale 1ns/1ps
module halving_sum_bank #(
  parameter int N_MAX = 16,
  parameter int W     = 16,
  parameter int CW    = $clog2(N_MAX + 1),
  parameter int IW    = $clog2(N_MAX)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic          fold_en_i,
  input  logic [IW-1:0] fold_idx_i,
  input  logic          pair_en_i,
  input  logic [CW-1:0] shift_i,
  input  logic [CW-1:0] pairs_i,
  output logic [W-1:0]  head_o
);
  localparam logic [CW:0] LIM_W = (CW+1)'(N_MAX);

  logic [W-1:0] arr_q [N_MAX];
  logic [W-1:0] nxt   [N_MAX];
  logic [W-1:0] fold_src;

  assign fold_src = arr_q[fold_idx_i];

  for (genvar i = 0; i < N_MAX; i++) begin : g_lane
    localparam logic [CW:0]   LANE = (CW+1)'(i);
    localparam logic [IW-1:0] SLOT = IW'(i);
    logic [CW:0]  pidx;
    logic [W-1:0] partner;
    logic         active, fold_hit;

    assign pidx     = LANE + {1'b0, shift_i};
    assign partner  = (pidx < LIM_W) ? arr_q[pidx[IW-1:0]] : '0;
    assign active   = pair_en_i && (LANE < {1'b0, pairs_i});
    assign fold_hit = fold_en_i && (LANE == '0);

    always_comb begin
      nxt[i] = arr_q[i];
      if (wr_en_i && (wr_idx_i == SLOT)) nxt[i] = wr_data_i;
      else if (active)                   nxt[i] = arr_q[i] + partner;
      else if (fold_hit)                 nxt[i] = arr_q[i] + fold_src;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N_MAX; k++) arr_q[k] <= '0;
    end else begin
      for (int k = 0; k < N_MAX; k++) arr_q[k] <= nxt[k];
    end
  end

  assign head_o = arr_q[0];

  // R7
  head_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pair_en_i && !fold_en_i && !wr_en_i) |=> $stable(arr_q[0]));
  // R2
  fold_apart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fold_en_i && pair_en_i));
endmodule

// File: rtl/halving_sum_unit.sv
`timescale 1ns/1ps
module halving_sum_unit #(
  parameter  int N_MAX = 16,
  parameter  int W     = 16,
  localparam int IW    = $clog2(N_MAX),
  localparam int CW    = $clog2(N_MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic          start_i,
  input  logic [CW-1:0] count_i,
  input  logic          mode_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [W-1:0]  sum_o
);
  logic          fold_en, pair_en, wr_ok;
  logic [IW-1:0] fold_idx;
  logic [CW-1:0] shift, pairs;
  logic [W-1:0]  head, res_q;

  assign wr_ok = wr_en_i && !busy_o;

  halving_sum_ctrl #(.N_MAX(N_MAX), .CW(CW), .IW(IW)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .count_i, .mode_i,
    .busy_o, .done_o,
    .fold_en_o(fold_en), .fold_idx_o(fold_idx),
    .pair_en_o(pair_en), .shift_o(shift), .pairs_o(pairs)
  );

  halving_sum_bank #(.N_MAX(N_MAX), .W(W), .CW(CW), .IW(IW)) u_bank (
    .clk_i, .rst_ni,
    .wr_en_i(wr_ok), .wr_idx_i, .wr_data_i,
    .fold_en_i(fold_en), .fold_idx_i(fold_idx),
    .pair_en_i(pair_en), .shift_i(shift), .pairs_i(pairs),
    .head_o(head)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     res_q <= '0;
    else if (done_o) res_q <= head;
  end

  assign sum_o = done_o ? head : res_q;

  // R5
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_o) |-> $stable(sum_o));
  // R11
  busy_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
endmodule

// File: tb/halving_sum_unit_tb.sv
`timescale 1ns/1ps
module halving_sum_unit_tb;
  localparam int N_MAX = 12;
  localparam int W     = 8;
  localparam int IW    = $clog2(N_MAX);
  localparam int CW    = $clog2(N_MAX + 1);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [IW-1:0] wr_idx_i = '0;
  logic [W-1:0]  wr_data_i = '0;
  logic          start_i = 1'b0;
  logic [CW-1:0] count_i = '0;
  logic          mode_i = 1'b0;
  logic          busy_o, done_o;
  logic [W-1:0]  sum_o;

  int total = 0;
  int bad   = 0;
  bit ended = 0;
  logic [W-1:0] model [N_MAX];

  always #5 clk_i = ~clk_i;

  halving_sum_unit #(.N_MAX(N_MAX), .W(W)) u_dut (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int flog2(input int n);
    int r = 0;
    while ((n >> (r + 1)) != 0) r++;
    return r;
  endfunction

  task automatic put(input int idx, input logic [W-1:0] val);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_idx_i = IW'(idx); wr_data_i = val;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    model[idx] = val;
  endtask

  task automatic load_rand(input int n);
    for (int k = 0; k < N_MAX; k++) put(k, W'($urandom));
    if (n < 0) $display("unused");
  endtask

  task automatic run(input int n, input int m, input bit disturb);
    logic [W-1:0] exp_sum = '0;
    int exp_cyc, cyc;
    for (int k = 0; k < n; k++) exp_sum = exp_sum + model[k];
    exp_cyc = (n == 1) ? 0 : 2 * ((m != 0) ? $clog2(n) : flog2(n));
    @(negedge clk_i);
    start_i = 1'b1; count_i = CW'(n); mode_i = m[0];
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o === 1'b1, "R11 busy after start", longint'(busy_o), 1);
    cyc = 0;
    if (disturb && !done_o) begin
      start_i = 1'b1; count_i = CW'(1); mode_i = ~m[0];
      wr_en_i = 1'b1; wr_idx_i = '0; wr_data_i = ~model[0];
      @(negedge clk_i);
      cyc++;
      start_i = 1'b0; wr_en_i = 1'b0;
    end
    while (!done_o && cyc < 100) begin
      @(negedge clk_i);
      cyc++;
    end
    chk(sum_o === exp_sum, (m != 0) ? "R3 ceiling total (R10 wrap)" : "R2 fold total (R10 wrap)",
        longint'(sum_o), longint'(exp_sum));
    chk(cyc == exp_cyc, disturb ? "R6 R7 latency under disturbance" : "R4 latency",
        cyc, exp_cyc);
    @(negedge clk_i);
    chk(done_o === 1'b0, "R5 done single cycle", longint'(done_o), 0);
    chk(busy_o === 1'b0, "R11 busy drops", longint'(busy_o), 0);
    chk(sum_o === exp_sum, "R5 result held", longint'(sum_o), longint'(exp_sum));
  endtask

  initial begin
    #2_000_000;
    if (!ended) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < N_MAX; k++) model[k] = '0;
    repeat (3) @(negedge clk_i);
    // R1
    chk(busy_o === 1'b0, "R1 busy at reset", longint'(busy_o), 0);
    chk(done_o === 1'b0, "R1 done at reset", longint'(done_o), 0);
    chk(sum_o === '0, "R1 sum at reset", longint'(sum_o), 0);
    rst_ni = 1'b1;

    // R8: zero and oversize counts
    for (int c = 0; c < 2; c++) begin
      @(negedge clk_i);
      start_i = 1'b1; count_i = (c == 0) ? CW'(0) : CW'(N_MAX + 1);
      @(negedge clk_i);
      start_i = 1'b0;
      chk(busy_o === 1'b0, "R8 bad count ignored", longint'(busy_o), 0);
      @(negedge clk_i);
      chk(done_o === 1'b0, "R8 no done", longint'(done_o), 0);
    end

    // R9 directed: single entry load, count 1
    put(0, 8'h3C);
    run(1, 0, 0);
    run(1, 1, 0);

    // every count in both modes
    for (int m = 0; m < 2; m++)
      for (int n = 1; n <= N_MAX; n++) begin
        load_rand(n);
        run(n, m, 0);
      end

    // R10: all ones, full bank, wraps to 12*255 mod 256
    for (int k = 0; k < N_MAX; k++) put(k, 8'hFF);
    run(N_MAX, 0, 0);
    for (int k = 0; k < N_MAX; k++) put(k, 8'hFF);
    run(N_MAX, 1, 0);

    // R6 R7 directed disturbance on odd counts
    load_rand(7);  run(7, 0, 1);
    load_rand(11); run(11, 1, 1);

    // random mix
    for (int t = 0; t < 24; t++) begin
      int n, m;
      bit d;
      n = int'($urandom_range(1, N_MAX));
      m = int'($urandom_range(0, 1));
      d = 1'($urandom_range(0, 1));
      load_rand(n);
      run(n, m, d);
    end

    ended = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule